// File: doc/BRIEF.md
# Serial Peripheral Slave Front End with Transfer Pause

This block is the byte-level receive and transmit stage of a serial peripheral slave. It runs entirely in the system clock domain. The chip select, serial clock, serial data input and pause inputs are sampled through two-flop synchronisers, and each is edge-detected before use. Data is captured on rising serial clock edges and driven on falling edges. Both clock polarities that share this phase rule work: the clock may idle low or high while the slave is deselected.

Received bytes go to the command controller as one-cycle strobes, together with pulses that mark the start and end of each frame. The end-of-frame pulse also reports whether the frame stopped on a byte boundary. The controller supplies the byte to shift out. A pause input freezes a transfer part-way through without losing the bit position. While paused, the serial output enable is dropped and clock and data activity is ignored. The pause is entered and left only while the serial clock is low.

Top module: `spi_hold_slave`

## Requirements
- R1: While reset is asserted, and after its release with the slave deselected, so_oe_o, rx_valid_o, frame_start_o, frame_end_o and frame_whole_o are all 0.
- R2: si_i is sampled on serial clock rising edges, most significant bit first. After every 8th rising edge within a frame, rx_valid_o pulses for one clock and rx_byte_o holds the assembled byte.
- R3: so_o presents bit 7 of tx_byte_i as captured at the chip-select falling edge. Each falling edge that follows a rising edge advances so_o by one bit toward bit 0. The falling edge after the 8th rising edge captures tx_byte_i afresh and presents its bit 7.
- R4: A serial clock falling edge that comes before the first rising edge after a byte load does not move so_o. This covers the leading edge when the clock idles high.
- R5: While cs_ni is high, so_oe_o is 0 and serial clock or data activity produces no rx_valid_o.
- R6: A cs_ni falling edge produces a one-clock frame_start_o pulse and clears the bit counter, so bits of an unfinished byte from an earlier frame are discarded.
- R7: A cs_ni rising edge produces a one-clock frame_end_o pulse. frame_whole_o is 1 when the frame ended on a byte boundary and 0 when a partial byte was pending.
- R8: hold_ni low, sampled while the serial clock is low, pauses the transfer. During the pause so_oe_o is 0, clock and data edges are ignored and the bit counter is frozen.
- R9: hold_ni high, sampled while the serial clock is low, resumes the transfer at the same bit position. so_oe_o returns to 1 and so_o shows the same bit.
- R10: A change of hold_ni while the serial clock is high has no effect until the serial clock is next low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous pin |
| sck_i | input | 1 | Serial clock pin |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| tx_byte_i | input | DATA_W | Byte to shift out, captured at frame start and at byte boundaries |
| rx_byte_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-clock strobe when rx_byte_o is updated |
| frame_start_o | output | 1 | One-clock pulse on chip-select fall |
| frame_end_o | output | 1 | One-clock pulse on chip-select rise |
| frame_whole_o | output | 1 | Frame ended on a byte boundary (valid from frame_end_o on) |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |

## Verification
Every pin change reaches the outputs three system clocks later: two synchroniser stages, then the registered action taken on the detected edge. The bench holds each serial clock phase for eight system clocks. It samples so_o and so_oe_o on the falling system clock edge at the end of a phase, long after the result is due. Strobes and frame pulses last one clock. A monitor therefore compares them on every falling system clock edge against the bytes and frame-end flags that the driver queued.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int unsigned NUM_PINS = 4;
  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_SCK  = 1;
  localparam int unsigned PIN_SI   = 2;
  localparam int unsigned PIN_HOLD = 3;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } pin_ev_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
  import spi_hold_pkg::*;
#(
  parameter int unsigned    N       = 4,
  parameter int unsigned    STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      pin_i,
  output pin_ev_t [N-1:0]   ev_o
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] stg_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q  <= {STAGES{RST_VAL[g]}};
        prev_q <= RST_VAL[g];
      end else begin
        stg_q  <= {stg_q[STAGES-2:0], pin_i[g]};
        prev_q <= stg_q[STAGES-1];
      end
    end

    assign ev_o[g].lvl  = stg_q[STAGES-1];
    assign ev_o[g].rise = stg_q[STAGES-1] & ~prev_q;
    assign ev_o[g].fall = ~stg_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_act_i,
  input  logic sck_lvl_i,
  input  logic hold_lvl_i,
  output logic paused_o
);

  // hold level is only looked at while SCK is low; a change with SCK high waits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        paused_o <= 1'b0;
    else if (!cs_act_i) paused_o <= 1'b0;
    else if (!sck_lvl_i) paused_o <= ~hold_lvl_i;
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              si_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              frame_whole_o,
  output logic              so_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-2:0] rx_sr_q;
  logic [DATA_W-1:0] tx_sr_q;
  logic              armed_q;  // a rising edge was seen since the last load/shift

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr_q       <= '0;
      tx_sr_q       <= '0;
      armed_q       <= 1'b0;
      bit_cnt_o     <= '0;
      rx_byte_o     <= '0;
      rx_valid_o    <= 1'b0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      frame_whole_o <= 1'b0;
    end else begin
      rx_valid_o    <= 1'b0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      if (cs_fall_i) begin
        frame_start_o <= 1'b1;
        bit_cnt_o     <= '0;
        armed_q       <= 1'b0;
        tx_sr_q       <= tx_byte_i;
      end else begin
        if (rise_i) begin
          rx_sr_q <= {rx_sr_q[DATA_W-3:0], si_i};
          armed_q <= 1'b1;
          if (bit_cnt_o == LAST_BIT) begin
            rx_byte_o  <= {rx_sr_q, si_i};
            rx_valid_o <= 1'b1;
            bit_cnt_o  <= '0;
          end else begin
            bit_cnt_o <= bit_cnt_o + 1'b1;
          end
        end
        if (fall_i && armed_q) begin
          armed_q <= 1'b0;
          if (bit_cnt_o == '0) tx_sr_q <= tx_byte_i;
          else                 tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
        end
      end
      if (cs_rise_i) begin
        frame_end_o   <= 1'b1;
        frame_whole_o <= (bit_cnt_o == '0);
      end
    end
  end

  assign so_o = tx_sr_q[DATA_W-1];

endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spi_hold_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_ni,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              frame_whole_o,
  output logic              so_o,
  output logic              so_oe_o
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [NUM_PINS-1:0] PIN_RST =
    (NUM_PINS'(1) << PIN_CS) | (NUM_PINS'(1) << PIN_HOLD);

  logic [NUM_PINS-1:0] pin_raw;
  pin_ev_t [NUM_PINS-1:0] ev;
  logic cs_act, sck_lvl, paused, run, rise_q, fall_q;
  logic [CNT_W-1:0] bit_cnt;
  logic unused_pin_edges;

  always_comb begin
    pin_raw           = '0;
    pin_raw[PIN_CS]   = cs_ni;
    pin_raw[PIN_SCK]  = sck_i;
    pin_raw[PIN_SI]   = si_i;
    pin_raw[PIN_HOLD] = hold_ni;
  end

  spi_pin_sync #(
    .N       (NUM_PINS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_raw),
    .ev_o   (ev)
  );

  assign cs_act  = ~ev[PIN_CS].lvl;
  assign sck_lvl = ev[PIN_SCK].lvl;
  assign unused_pin_edges = ^{ev[PIN_SI].rise, ev[PIN_SI].fall,
                              ev[PIN_HOLD].rise, ev[PIN_HOLD].fall};

  spi_hold_ctl u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sck_lvl_i  (sck_lvl),
    .hold_lvl_i (ev[PIN_HOLD].lvl),
    .paused_o   (paused)
  );

  assign run    = cs_act & ~paused;
  assign rise_q = ev[PIN_SCK].rise & run;
  assign fall_q = ev[PIN_SCK].fall & run;

  spi_shift_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cs_fall_i     (ev[PIN_CS].fall),
    .cs_rise_i     (ev[PIN_CS].rise),
    .rise_i        (rise_q),
    .fall_i        (fall_q),
    .si_i          (ev[PIN_SI].lvl),
    .tx_byte_i     (tx_byte_i),
    .rx_byte_o     (rx_byte_o),
    .rx_valid_o    (rx_valid_o),
    .frame_start_o (frame_start_o),
    .frame_end_o   (frame_end_o),
    .frame_whole_o (frame_whole_o),
    .so_o          (so_o),
    .bit_cnt_o     (bit_cnt)
  );

  assign so_oe_o = run;

endmodule

// File: rtl/spi_hold_slave_chk.sv
module spi_hold_slave_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_valid_o,
  input logic             frame_start_o,
  input logic             frame_end_o,
  input logic             cs_act,
  input logic             sck_lvl,
  input logic             paused,
  input logic             rise_q,
  input logic [CNT_W-1:0] bit_cnt
);

  // R2
  rx_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rise_q));

  // R5
  idle_no_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !rx_valid_o);

  // R6
  start_clears_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (bit_cnt == '0));

  // R7
  end_after_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> $past(!cs_act));

  // R8
  pause_freezes_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused |=> $stable(bit_cnt));

  // R10
  pause_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused) |-> $past(!sck_lvl));

endmodule

bind spi_hold_slave spi_hold_slave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_valid_o    (rx_valid_o),
  .frame_start_o (frame_start_o),
  .frame_end_o   (frame_end_o),
  .cs_act        (cs_act),
  .sck_lvl       (sck_lvl),
  .paused        (paused),
  .rise_q        (rise_q),
  .bit_cnt       (bit_cnt)
);

// File: tb/spi_hold_slave_tb.sv
module spi_hold_slave_tb;
  localparam int HP = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, sck, si, hold_n;
  logic [7:0] tx_byte;
  logic [7:0] rx_byte;
  logic rx_valid, frame_start, frame_end, frame_whole, so, so_oe;

  int nchk = 0, nerr = 0;
  int starts_exp = 0, starts_seen = 0, rx_seen = 0;
  logic [7:0] rx_q[$];
  logic whole_q[$];
  bit done = 1'b0;

  spi_hold_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .tx_byte_i(tx_byte), .rx_byte_o(rx_byte),
    .rx_valid_o(rx_valid), .frame_start_o(frame_start), .frame_end_o(frame_end),
    .frame_whole_o(frame_whole), .so_o(so), .so_oe_o(so_oe)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard for received bytes and frame-end flags
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_seen++;
        if (rx_q.size() == 0) chk_eq("R2 unexpected rx strobe", rx_byte, -1);
        else chk_eq("R2 rx byte", rx_byte, rx_q.pop_front());
      end
      if (frame_start) starts_seen++;
      if (frame_end) begin
        if (whole_q.size() == 0) chk_eq("R7 unexpected frame end", 1, 0);
        else chk_eq("R7 frame_whole", frame_whole, whole_q.pop_front());
      end
    end
  end

  task automatic frame_begin(input logic [7:0] first_tx);
    tx_byte = first_tx;
    wt(HP);
    cs_n = 1'b0;
    starts_exp++;
    wt(HP);
    chk_eq("R5 oe after select", so_oe, 1);
  endtask

  task automatic frame_close(input logic exp_whole, input bit idle_high);
    if (!idle_high) begin sck = 1'b0; wt(HP); end
    whole_q.push_back(exp_whole);
    cs_n = 1'b1;
    wt(2*HP);
    chk_eq("R5 oe after deselect", so_oe, 0);
  endtask

  task automatic xfer(input logic [7:0] mosi, input logic [7:0] miso, input int n_bits,
                      input int lo_at, input int hi_at, input string stag);
    tx_byte = miso;
    if (n_bits == 8) rx_q.push_back(mosi);
    for (int i = 7; i > 7 - n_bits; i--) begin
      sck = 1'b0;
      if (i == lo_at) begin
        wt(HP);
        hold_n = 1'b0;
        wt(HP);
        chk_eq("R8 oe in pause", so_oe, 0);
        sck = 1'b1; si = ~mosi[i]; wt(HP);
        sck = 1'b0; si = mosi[i];  wt(HP);
        sck = 1'b1; si = ~mosi[i]; wt(HP);
        hold_n = 1'b1;
        wt(HP);
        chk_eq("R10 release with sck high deferred", so_oe, 0);
        sck = 1'b0;
        wt(HP);
        chk_eq("R9 oe after resume", so_oe, 1);
      end
      si = mosi[i];
      wt(HP);
      chk_eq({stag, " so bit"}, so, miso[i]);
      sck = 1'b1;
      wt(HP);
      if (i == hi_at) begin
        hold_n = 1'b0;
        wt(HP);
        chk_eq("R10 hold with sck high deferred", so_oe, 1);
        sck = 1'b0;
        wt(HP);
        chk_eq("R8 paused once sck low", so_oe, 0);
        hold_n = 1'b1;
        wt(HP);
        chk_eq("R9 resumed", so_oe, 1);
      end
    end
  endtask

  initial begin
    int seen0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1; tx_byte = '0;
    wt(4);
    // R1 reset state
    chk_eq("R1 so_oe", so_oe, 0);
    chk_eq("R1 rx_valid", rx_valid, 0);
    chk_eq("R1 frame_start", frame_start, 0);
    chk_eq("R1 frame_end", frame_end, 0);
    chk_eq("R1 frame_whole", frame_whole, 0);
    rst_n = 1'b1;
    wt(6);
    chk_eq("R1 oe after release", so_oe, 0);

    // mode (0,0), two bytes: R2 R3
    frame_begin(8'hA5);
    xfer(8'h3C, 8'hA5, 8, -1, -1, "R3");
    xfer(8'hC3, 8'h5A, 8, -1, -1, "R3");
    frame_close(1'b1, 1'b0);

    // R5: activity while deselected
    seen0 = rx_seen;
    for (int k = 0; k < 16; k++) begin sck = ~sck; si = k[0]; wt(HP); end
    chk_eq("R5 no rx while deselected", rx_seen, seen0);
    chk_eq("R5 oe while deselected", so_oe, 0);

    // mode (1,1): R4
    sck = 1'b1; wt(HP);
    frame_begin(8'h96);
    xfer(8'h81, 8'h96, 8, -1, -1, "R4");
    xfer(8'h7E, 8'h33, 8, -1, -1, "R4");
    frame_close(1'b1, 1'b1);

    // partial frame then fresh frame: R6 R7
    sck = 1'b0; wt(HP);
    frame_begin(8'hF0);
    xfer(8'h55, 8'hF0, 3, -1, -1, "R3");
    frame_close(1'b0, 1'b0);
    frame_begin(8'h0F);
    xfer(8'hE7, 8'h0F, 8, -1, -1, "R6");
    chk_eq("R6 fresh byte after partial frame", rx_byte, 8'hE7);
    frame_close(1'b1, 1'b0);

    // pause: R8 R9 R10
    frame_begin(8'h6D);
    xfer(8'h2B, 8'h6D, 8, 4, -1, "R9");
    xfer(8'hD4, 8'hB2, 8, -1, 3, "R9");
    frame_close(1'b1, 1'b0);

    wt(HP);
    chk_eq("R2 all bytes received", rx_q.size(), 0);
    chk_eq("R7 all frame ends seen", whole_q.size(), 0);
    chk_eq("R6 frame start pulses", starts_seen, starts_exp);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule